// File: doc/BRIEF.md
# MDIO Management Register Interface

This block is a management controller for the serial MDIO bus. Software reaches external PHY registers by writing one 32-bit command word. The word holds a PHY address, a register address, a direction bit and, for writes, sixteen data bits. The controller then builds the full serial frame and produces the MDC clock from the system clock. It shifts the frame out on MDIO and, for a read, takes in the sixteen returned bits.

Software follows the transaction through the same word. A busy flag reads as 1 for the whole frame. When a read finishes, a read-valid flag goes high and the PHY's data appears in the low half of the word. A second, independent register holds the PHY address assigned to this port. It can be written and read back at any time.

Top module: `mdio_mgmt_port`

## Requirements
- R1: After reset the command word reads 0, the port-address register reads 0, MDC is low and MDIO is not driven (`mdio_oe` = 0).
- R2: Command word layout (`reg_addr` = 0): bits 15:0 data, 20:16 PHY address, 25:21 register address, 26 direction (1 = read, 0 = write), 27 read-valid (read only), 28 busy (read only), 31:29 read as 0. The PHY and register address fields are 5 bits wide, so values above 31 cannot be encoded.
- R3: A command write accepted while idle sets busy on the next clock. Busy then stays 1 for exactly 128·DIV_HALF clocks, counted from the accepting edge.
- R4: MDC is low whenever the block is idle. During a frame it has a period of 2·DIV_HALF clocks, and its first rising edge comes DIV_HALF clocks after the accepting edge.
- R5: The transmitted frame is 32 ones, then 0 1, then the direction pair (1 0 read, 0 1 write), then the PHY address and the register address, each MSB first. A write then sends the turnaround 1 0 and the 16 data bits MSB first. `mdio_o` changes only when MDC falls, and bit k is driven from 2k·DIV_HALF to 2(k+1)·DIV_HALF clocks after the accepting edge.
- R6: In a read frame the block releases MDIO (`mdio_oe` = 0) from the first turnaround bit (bit 46) to the end of the frame. In a write frame it drives MDIO for all 64 bits.
- R7: In a read, `mdio_i` is sampled at each MDC rising edge of bits 48 to 63. The result is placed MSB first in bits 15:0. Read-valid rises on the same clock that busy falls.
- R8: A command write while busy is 1 is ignored: the fields stay unchanged and the frame in flight is unaffected.
- R9: Read-valid clears on the clock after a new command write is accepted.
- R10: The port-address register (`reg_addr` = 1) holds 5 bits, stored from `reg_wdata[4:0]` and read back in bits 4:0 with the other bits 0. It may be written even while busy, with no effect on the frame.
- R11: After a write frame completes, read-valid stays 0 and the data field still holds the written data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register select: 0 command word, 1 port address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the selected register (combinational) |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Serial data out |
| mdio_oe | output | 1 | Output enable for the MDIO pad |
| mdio_i | input | 1 | Serial data in |

## Verification
The hardest case is a command write that lands while a frame is already running. A stray write must change neither the stored fields nor the bits already on the wire. A port-address write in the middle of a frame must also leave the frame alone. The stimulus issues both kinds of write some tens of clocks into a write frame. A reference model that counts clocks from the accepting edge predicts MDC, the driven bit, the output enable and the readback value on every cycle. The same model acts as the PHY during reads: it places the return pattern on `mdio_i` at the bit positions it has computed, so that the sampled data is checked against an independent bit order.

// File: rtl/mdio_mgmt_pkg.sv
package mdio_mgmt_pkg;
   localparam int DATA_LSB = 0;
   localparam int PHY_LSB  = 16;
   localparam int REGA_LSB = 21;
   localparam int DIR_BIT  = 26;
   localparam int RVLD_BIT = 27;
   localparam int BUSY_BIT = 28;
   localparam int ADDR_W   = 5;
   localparam int DATA_W   = 16;

   typedef struct packed {
      logic              rd;
      logic [ADDR_W-1:0] rega;
      logic [ADDR_W-1:0] phy;
      logic [DATA_W-1:0] data;
   } cmd_fields_t;
endpackage

// File: rtl/mdio_clk_div.sv
module mdio_clk_div #(
   parameter int DIV_HALF = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en_i,
   output logic mdc_o,
   output logic rise_o,
   output logic fall_o
);
   localparam int CW = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;

   generate
      if (DIV_HALF < 1) begin : g_bad_div
         $error("DIV_HALF must be at least 1");
      end
   endgenerate

   logic [CW-1:0] cnt_q;
   logic          wrap;

   assign wrap   = (cnt_q == CW'(DIV_HALF - 1));
   assign rise_o = en_i && wrap && !mdc_o;
   assign fall_o = en_i && wrap && mdc_o;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         mdc_o <= 1'b0;
      end else if (!en_i) begin
         cnt_q <= '0;
         mdc_o <= 1'b0;
      end else if (wrap) begin
         cnt_q <= '0;
         mdc_o <= ~mdc_o;
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   // R4: clock parks low once the engine stops requesting it
   p_mdc_idle_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !en_i |=> !mdc_o);
endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
   import mdio_mgmt_pkg::*;
#(
   parameter int PRE_LEN = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  cmd_fields_t       cmd_i,
   input  logic              rise_i,
   input  logic              fall_i,
   input  logic              mdio_i,
   output logic              busy_o,
   output logic              finish_o,
   output logic              mdio_o,
   output logic              mdio_oe_o,
   output logic [DATA_W-1:0] rdata_o
);
   localparam int FRAME_LEN = PRE_LEN + 32;
   localparam int IDX_W     = $clog2(FRAME_LEN);
   localparam int TA_IDX    = PRE_LEN + 14;
   localparam int DAT_IDX   = PRE_LEN + 16;

   generate
      if (PRE_LEN < 0 || PRE_LEN > 32) begin : g_bad_pre
         $error("PRE_LEN must lie in 0..32");
      end
   endgenerate

   logic [FRAME_LEN-1:0] shreg_q;
   logic [FRAME_LEN-1:0] frame;
   logic [31:0]          body;
   logic [IDX_W-1:0]     idx_q;
   logic                 rd_q;
   logic                 last_bit;

   assign body = {2'b01,
                  cmd_i.rd ? 2'b10 : 2'b01,
                  cmd_i.phy, cmd_i.rega,
                  cmd_i.rd ? 2'b11 : 2'b10,
                  cmd_i.rd ? {DATA_W{1'b1}} : cmd_i.data};

   generate
      if (PRE_LEN == 0) begin : g_no_pre
         assign frame = body;
      end else begin : g_pre
         assign frame = {{PRE_LEN{1'b1}}, body};
      end
   endgenerate

   assign last_bit  = (idx_q == IDX_W'(FRAME_LEN - 1));
   assign finish_o  = busy_o && fall_i && last_bit;
   assign mdio_o    = shreg_q[FRAME_LEN-1];
   assign mdio_oe_o = busy_o && !(rd_q && (idx_q >= IDX_W'(TA_IDX)));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shreg_q <= '1;
         idx_q   <= '0;
         rd_q    <= 1'b0;
         busy_o  <= 1'b0;
         rdata_o <= '0;
      end else if (start_i) begin
         shreg_q <= frame;
         idx_q   <= '0;
         rd_q    <= cmd_i.rd;
         busy_o  <= 1'b1;
      end else if (busy_o) begin
         if (rise_i && rd_q && (idx_q >= IDX_W'(DAT_IDX)))
            rdata_o <= {rdata_o[DATA_W-2:0], mdio_i};
         if (fall_i) begin
            if (last_bit) begin
               busy_o <= 1'b0;
            end else begin
               idx_q   <= idx_q + 1'b1;
               shreg_q <= {shreg_q[FRAME_LEN-2:0], 1'b1};
            end
         end
      end
   end

   // R5: data line moves only on a falling MDC edge or at frame load
   p_mdio_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && !fall_i && !start_i) |=> $stable(mdio_o));
   // R3: completion ends the busy period on the next clock
   p_finish_ends_r3: assert property (@(posedge clk) disable iff (!rst_n)
      finish_o |=> !busy_o);
   // R8: the register front end never launches over a running frame
   p_start_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
      start_i |-> !busy_o);
endmodule

// File: rtl/mdio_mgmt_port.sv
module mdio_mgmt_port
   import mdio_mgmt_pkg::*;
#(
   parameter int DIV_HALF = 4,
   parameter int PRE_LEN  = 32
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        reg_wr,
   input  logic        reg_addr,
   input  logic [31:0] reg_wdata,
   output logic [31:0] reg_rdata,
   output logic        mdc,
   output logic        mdio_o,
   output logic        mdio_oe,
   input  logic        mdio_i
);
   cmd_fields_t       cmd_q;
   logic              rvld_q;
   logic [ADDR_W-1:0] own_q;
   logic              busy, finish, rise, fall, accept, cmd_wr;
   logic [DATA_W-1:0] rx_data;

   assign cmd_wr = reg_wr && !reg_addr;
   assign accept = cmd_wr && !busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmd_q  <= '0;
         rvld_q <= 1'b0;
         own_q  <= '0;
      end else begin
         if (accept) begin
            cmd_q.data <= reg_wdata[DATA_LSB +: DATA_W];
            cmd_q.phy  <= reg_wdata[PHY_LSB  +: ADDR_W];
            cmd_q.rega <= reg_wdata[REGA_LSB +: ADDR_W];
            cmd_q.rd   <= reg_wdata[DIR_BIT];
            rvld_q     <= 1'b0;
         end else if (finish && cmd_q.rd) begin
            cmd_q.data <= rx_data;
            rvld_q     <= 1'b1;
         end
         if (reg_wr && reg_addr)
            own_q <= reg_wdata[ADDR_W-1:0];
      end
   end

   always_comb begin
      reg_rdata = '0;
      if (reg_addr) begin
         reg_rdata[ADDR_W-1:0] = own_q;
      end else begin
         reg_rdata[DATA_LSB +: DATA_W] = cmd_q.data;
         reg_rdata[PHY_LSB  +: ADDR_W] = cmd_q.phy;
         reg_rdata[REGA_LSB +: ADDR_W] = cmd_q.rega;
         reg_rdata[DIR_BIT]            = cmd_q.rd;
         reg_rdata[RVLD_BIT]           = rvld_q;
         reg_rdata[BUSY_BIT]           = busy;
      end
   end

   mdio_clk_div #(.DIV_HALF(DIV_HALF)) u_div (
      .clk(clk), .rst_n(rst_n), .en_i(busy),
      .mdc_o(mdc), .rise_o(rise), .fall_o(fall));

   mdio_frame_engine #(.PRE_LEN(PRE_LEN)) u_eng (
      .clk(clk), .rst_n(rst_n), .start_i(accept),
      .cmd_i({reg_wdata[DIR_BIT], reg_wdata[REGA_LSB +: ADDR_W],
              reg_wdata[PHY_LSB +: ADDR_W], reg_wdata[DATA_LSB +: DATA_W]}),
      .rise_i(rise), .fall_i(fall), .mdio_i(mdio_i),
      .busy_o(busy), .finish_o(finish), .mdio_o(mdio_o),
      .mdio_oe_o(mdio_oe), .rdata_o(rx_data));

   // R8: a command arriving during a frame leaves the stored fields alone
   p_ignore_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_wr && busy) |=> $stable({cmd_q.rd, cmd_q.rega, cmd_q.phy}));
   // R9: an accepted command withdraws the previous read result
   p_rvalid_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> !rvld_q);
   // R7: read-valid appears only at the end of a read frame
   p_rvalid_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rvld_q) |-> (cmd_q.rd && !busy && $fell(busy)));
endmodule

// File: tb/mdio_mgmt_port_bench.sv
module mdio_mgmt_port_bench;
   localparam int H   = 4;
   localparam int LEN = 128 * H;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic        reg_addr = 1'b0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        mdc, mdio_o, mdio_oe;
   logic        mdio_i = 1'b1;

   int chk_n = 0;
   int fail_n = 0;
   int cyc = 0;
   bit run_chk = 1'b0;

   // reference model state
   bit          m_busy = 0, m_rv = 0, m_rd = 0;
   int          t = 0;
   logic [4:0]  m_phy = '0, m_reg = '0, m_own = '0;
   logic [15:0] m_data = '0, rd_pat = '0;

   always #2 clk = ~clk;

   mdio_mgmt_port u_mdio_mgmt_port (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc),
      .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i));

   task automatic check(input bit ok, input string tag, input logic [31:0] act,
                        input logic [31:0] exp);
      chk_n++;
      if (!ok) begin
         fail_n++;
         $display("FAIL %s at cycle %0d: actual %h expected %h", tag, cyc, act, exp);
      end
   endtask

   function automatic logic exp_bit(int k);
      if (k < 32)  return 1'b1;
      if (k == 32) return 1'b0;
      if (k == 33) return 1'b1;
      if (k == 34) return m_rd;
      if (k == 35) return !m_rd;
      if (k < 41)  return m_phy[40 - k];
      if (k < 46)  return m_reg[45 - k];
      if (k == 46) return 1'b1;
      if (k == 47) return 1'b0;
      return m_data[63 - k];
   endfunction

   function automatic logic [31:0] exp_rd();
      if (reg_addr) return {27'd0, m_own};
      return {3'b000, m_busy, m_rv, m_rd, m_reg, m_phy, m_data};
   endfunction

   // model advances on each active edge
   always @(posedge clk) begin
      cyc++;
      if (!rst_n) begin
         m_busy = 0; m_rv = 0; m_rd = 0; t = 0;
         m_phy = '0; m_reg = '0; m_data = '0; m_own = '0;
      end else begin
         if (m_busy) begin
            t++;
            if (t == LEN) begin
               m_busy = 0;
               if (m_rd) begin m_data = rd_pat; m_rv = 1; end
            end
         end else if (reg_wr && !reg_addr) begin
            m_busy = 1; t = 0; m_rv = 0;
            m_data = reg_wdata[15:0]; m_phy = reg_wdata[20:16];
            m_reg = reg_wdata[25:21]; m_rd = reg_wdata[26];
         end
         if (reg_wr && reg_addr) m_own = reg_wdata[4:0];
      end
   end

   // PHY side of the model: drive return bits during the read data phase
   always @(negedge clk) begin
      if (m_busy && m_rd && (t / (2 * H)) >= 48) mdio_i <= rd_pat[63 - t / (2 * H)];
      else mdio_i <= 1'b1;
   end

   // per-cycle comparison, away from the edge
   always @(posedge clk) begin
      #1;
      if (rst_n && run_chk) begin
         logic e_mdc, e_oe;
         int k;
         k = t / (2 * H);
         e_mdc = m_busy && (((t / H) % 2) == 1);
         e_oe  = m_busy && !(m_rd && k >= 46);
         check(mdc == e_mdc, "R4 mdc", {31'd0, mdc}, {31'd0, e_mdc});
         check(mdio_oe == e_oe, "R6 mdio_oe", {31'd0, mdio_oe}, {31'd0, e_oe});
         if (e_oe)
            check(mdio_o == exp_bit(k), "R5 mdio_o", {31'd0, mdio_o}, {31'd0, exp_bit(k)});
         check(reg_rdata == exp_rd(), "R2/R3 readback", reg_rdata, exp_rd());
      end
   end

   always @(posedge clk) begin
      if (cyc > 150000) begin
         fail_n++;
         $display("FAIL watchdog expired");
         $display("End of test - %0d assertions evaluated, %0d failures", chk_n, fail_n);
         $finish;
      end
   end

   task automatic wr(input logic a, input logic [31:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0; reg_addr = 1'b0;
   endtask

   function automatic logic [31:0] cmd(input bit rd, input logic [4:0] ra,
                                       input logic [4:0] pa, input logic [15:0] d);
      return {5'd0, rd, ra, pa, d};
   endfunction

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check(reg_rdata == 32'd0, "R1 command word", reg_rdata, 32'd0);
      check(mdc == 1'b0 && mdio_oe == 1'b0, "R1 pins", {30'd0, mdc, mdio_oe}, 32'd0);
      reg_addr = 1'b1; #0.5;
      check(reg_rdata == 32'd0, "R1 port address", reg_rdata, 32'd0);
      reg_addr = 1'b0;
      run_chk = 1'b1;

      // R10 port address write/read
      wr(1'b1, 32'hFFFF_FFF3);
      reg_addr = 1'b1; #0.5;
      check(reg_rdata == 32'h13, "R10 port address", reg_rdata, 32'h13);
      reg_addr = 1'b0;

      // write frame, with writes landing mid-frame
      wr(1'b0, cmd(1'b0, 5'h1A, 5'h05, 16'hA5C3));
      #0.5;
      check(reg_rdata[28] == 1'b1, "R3 busy set", reg_rdata, 32'h1000_0000);
      repeat (40) @(negedge clk);
      wr(1'b0, cmd(1'b1, 5'h03, 5'h11, 16'h0F0F));   // R8 ignored
      #0.5;
      check(reg_rdata[26:0] == cmd(1'b0, 5'h1A, 5'h05, 16'hA5C3) >> 0,
            "R8 fields kept", reg_rdata, cmd(1'b0, 5'h1A, 5'h05, 16'hA5C3));
      wr(1'b1, 32'h0000_000A);                        // R10 mid-frame
      repeat (LEN) @(negedge clk);
      check(reg_rdata == cmd(1'b0, 5'h1A, 5'h05, 16'hA5C3),
            "R11 after write", reg_rdata, cmd(1'b0, 5'h1A, 5'h05, 16'hA5C3));
      reg_addr = 1'b1; #0.5;
      check(reg_rdata == 32'h0A, "R10 mid-frame write", reg_rdata, 32'h0A);
      reg_addr = 1'b0;

      // read frame
      rd_pat = 16'h6E91;
      wr(1'b0, cmd(1'b1, 5'h00, 5'h1F, 16'h1234));
      repeat (LEN + 2) @(negedge clk);
      check(reg_rdata == (cmd(1'b1, 5'h00, 5'h1F, 16'h6E91) | 32'h0800_0000),
            "R7 read result", reg_rdata, cmd(1'b1, 5'h00, 5'h1F, 16'h6E91) | 32'h0800_0000);

      // R9 new command clears read-valid
      wr(1'b0, cmd(1'b1, 5'h1F, 5'h00, 16'h0000));
      rd_pat = 16'h8001;
      #0.5;
      check(reg_rdata[27] == 1'b0, "R9 rvalid cleared", reg_rdata, 32'd0);
      repeat (LEN + 2) @(negedge clk);
      check(reg_rdata[27] == 1'b1 && reg_rdata[15:0] == 16'h8001,
            "R7 second read", reg_rdata, cmd(1'b1, 5'h1F, 5'h00, 16'h8001) | 32'h0800_0000);

      // write frame with all-ones fields
      wr(1'b0, cmd(1'b0, 5'h1F, 5'h1F, 16'hFFFF));
      repeat (LEN + 2) @(negedge clk);
      check(reg_rdata[27] == 1'b0 && reg_rdata[15:0] == 16'hFFFF,
            "R11 rvalid stays low", reg_rdata, cmd(1'b0, 5'h1F, 5'h1F, 16'hFFFF));
      check(mdc == 1'b0 && mdio_oe == 1'b0, "R4 idle pins", {30'd0, mdc, mdio_oe}, 32'd0);

      repeat (4) @(negedge clk);
      $display("End of test - %0d assertions evaluated, %0d failures", chk_n, fail_n);
      $finish;
   end
endmodule